// File: doc/BRIEF.md
# ECC Fault Injection and Error Capture Unit

This unit sits beside the SEC-DED encoder and decoder of a 64-bit memory path that carries an 8-bit check byte. On the write path it can corrupt the outgoing data and check byte on purpose. A 32-bit mask is XORed into each half of the data word and an 8-bit mask into the check byte. A mirror option stores a copy of the lowest data byte in place of the computed check byte. Both are active only while a global injection enable is set. This lets firmware plant known errors and then read them back, either directly or through the read phase of a read-modify-write.

On the read path the decoder reports one beat at a time, flagging a corrected single-bit error, an uncorrectable multi-bit error or a memory-select error. The unit keeps a saturating count of single-bit errors and compares it against a threshold. It holds sticky detect flags, which software clears by writing 1. It records the address, data, check byte and transaction attributes of the first error and keeps that record until software clears it. A level interrupt is raised from the flags that software has enabled. Each error class can also be suppressed.

Top module: `ecc_fault_ctl`

## Requirements
- R1: While injection enable (offset 2 bit 9) is 0, `wr_data_out` equals `wr_data_in` and `wr_chk_out` equals `wr_chk_in`, whatever the masks and the mirror bit hold.
- R2: While injection enable is 1, `wr_data_out[63:32]` is `wr_data_in[63:32]` XOR the high mask (offset 0) and `wr_data_out[31:0]` is `wr_data_in[31:0]` XOR the low mask (offset 1). `wr_chk_out` is the check byte XOR the check mask (offset 2 bits 7:0).
- R3: With injection enabled and mirror (offset 2 bit 8) set, the check byte fed to the mask XOR is `wr_data_in[7:0]` instead of `wr_chk_in`.
- R4: Offset 3 holds the single-bit count in bits 7:0 and the threshold in bits 15:8. All writes honour the byte strobes `reg_wstrb`, so either field can be written without changing the other.
- R5: Each read beat with a single-bit error that is not disabled adds one to the count. The count saturates at 255. A software write to the count byte in the same cycle takes precedence.
- R6: The single-bit detect flag (offset 4 bit 0) is set on such a beat when the updated count is at or above the threshold. A threshold of 0 therefore flags every such error.
- R7: Offset 4 holds sticky flags: bit 1 multi-bit and bit 2 memory-select, each set by its enabled error. Bit 3 is set when an error is recorded while any of bits 2:0 is already set. Writing 1 to a bit clears it; a set in the same cycle wins.
- R8: Offset 5 bits 0, 1 and 2 suppress single-bit, multi-bit and memory-select errors respectively. A suppressed error changes no flag, no count and no capture.
- R9: The first enabled error stores its address (offset 7), data high and low (8, 9), check byte (10) and attributes (11: beat 2:0, size 6:4, source 12:8, type 17:16, valid 31). Later errors leave these unchanged while valid is set. Any write to offset 12 zeroes all capture registers.
- R10: `irq` is high exactly when some flag among offset 4 bits 2:0 is set and its enable in offset 6 (same bit positions) is set.
- R11: After reset every register reads 0 and `irq` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register word offset |
| reg_wdata | input | 32 | Register write data |
| reg_wstrb | input | 4 | Byte strobes for register write |
| reg_rdata | output | 32 | Register read data (combinational) |
| wr_data_in | input | 64 | Write data from host |
| wr_chk_in | input | 8 | Check byte from encoder |
| wr_data_out | output | 64 | Write data toward memory |
| wr_chk_out | output | 8 | Check byte toward memory |
| rd_valid | input | 1 | Read beat status valid |
| rd_sbe | input | 1 | Beat had a corrected single-bit error |
| rd_mbe | input | 1 | Beat had an uncorrectable error |
| rd_mse | input | 1 | Beat had a memory-select error |
| rd_addr | input | AW | Address of the beat |
| rd_data | input | 64 | Raw data of the beat |
| rd_chk | input | 8 | Raw check byte of the beat |
| rd_beat | input | 3 | Beat number in the burst |
| rd_size | input | 3 | Transaction size code |
| rd_src | input | 5 | Transaction source id |
| rd_type | input | 2 | Transaction type code |
| irq | output | 1 | Error interrupt |

## Verification
The bench aims at the boundaries of the count. It drives the count to the edge of saturation, where a wrapping counter would read 0 after 255. It also places the threshold crossing exactly on the third error, so a design that compared the old count would raise the flag one error late. Capture is hit twice, to check that a design which overwrote the record would lose the first address. Narrow byte-strobe writes go to the shared count and threshold register, so a full-word write would corrupt the neighbouring field. Write-1-to-clear is applied to one detect bit at a time, and suppressed errors are checked for leaks into the count and the capture valid bit.

// File: rtl/ecc_fault_ctl.sv
module ecc_fault_ctl #(
  parameter int AW = 32,
  parameter int DW = 64,
  parameter int CW = 8,
  parameter int RAW = 4
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           reg_we,
  input  logic [RAW-1:0] reg_addr,
  input  logic [31:0]    reg_wdata,
  input  logic [3:0]     reg_wstrb,
  output logic [31:0]    reg_rdata,
  input  logic [DW-1:0]  wr_data_in,
  input  logic [CW-1:0]  wr_chk_in,
  output logic [DW-1:0]  wr_data_out,
  output logic [CW-1:0]  wr_chk_out,
  input  logic           rd_valid,
  input  logic           rd_sbe,
  input  logic           rd_mbe,
  input  logic           rd_mse,
  input  logic [AW-1:0]  rd_addr,
  input  logic [DW-1:0]  rd_data,
  input  logic [CW-1:0]  rd_chk,
  input  logic [2:0]     rd_beat,
  input  logic [2:0]     rd_size,
  input  logic [4:0]     rd_src,
  input  logic [1:0]     rd_type,
  output logic           irq
);
  localparam int HW = DW / 2;
  localparam logic [7:0] CNT_MAX = 8'hFF;

  localparam logic [RAW-1:0] A_MHI  = RAW'(0);
  localparam logic [RAW-1:0] A_MLO  = RAW'(1);
  localparam logic [RAW-1:0] A_ICTL = RAW'(2);
  localparam logic [RAW-1:0] A_SBE  = RAW'(3);
  localparam logic [RAW-1:0] A_DET  = RAW'(4);
  localparam logic [RAW-1:0] A_DIS  = RAW'(5);
  localparam logic [RAW-1:0] A_IEN  = RAW'(6);
  localparam logic [RAW-1:0] A_CADR = RAW'(7);
  localparam logic [RAW-1:0] A_CHI  = RAW'(8);
  localparam logic [RAW-1:0] A_CLO  = RAW'(9);
  localparam logic [RAW-1:0] A_CCHK = RAW'(10);
  localparam logic [RAW-1:0] A_CATR = RAW'(11);
  localparam logic [RAW-1:0] A_CCLR = RAW'(12);

  logic [HW-1:0] mask_hi, mask_lo;
  logic [CW-1:0] mask_chk;
  logic          inj_en, mirror;
  logic [7:0]    cnt, thr;
  logic [3:0]    det;
  logic [2:0]    dis, ien;
  logic [AW-1:0] cap_addr;
  logic [DW-1:0] cap_data;
  logic [CW-1:0] cap_chk;
  logic [2:0]    cap_beat, cap_size;
  logic [4:0]    cap_src;
  logic [1:0]    cap_type;
  logic          cap_valid;

  wire [31:0] wmask = {{8{reg_wstrb[3]}}, {8{reg_wstrb[2]}}, {8{reg_wstrb[1]}}, {8{reg_wstrb[0]}}};
  function automatic logic [31:0] merge(input logic [31:0] old, input logic [31:0] wd, input logic [31:0] m);
    return (old & ~m) | (wd & m);
  endfunction

  wire wr_mhi  = reg_we && reg_addr == A_MHI;
  wire wr_mlo  = reg_we && reg_addr == A_MLO;
  wire wr_ictl = reg_we && reg_addr == A_ICTL;
  wire wr_sbe  = reg_we && reg_addr == A_SBE;
  wire wr_det  = reg_we && reg_addr == A_DET;
  wire wr_dis  = reg_we && reg_addr == A_DIS;
  wire wr_ien  = reg_we && reg_addr == A_IEN;
  wire wr_cclr = reg_we && reg_addr == A_CCLR;

  // Write path
  wire [CW-1:0] chk_src = mirror ? wr_data_in[CW-1:0] : wr_chk_in;
  assign wr_data_out = inj_en ? (wr_data_in ^ {mask_hi, mask_lo}) : wr_data_in;
  assign wr_chk_out  = inj_en ? (chk_src ^ mask_chk) : wr_chk_in;

  // Read path event decode
  wire [2:0] ev      = rd_valid ? ({rd_mse, rd_mbe, rd_sbe} & ~dis) : 3'b000;
  wire [7:0] cnt_inc = (cnt == CNT_MAX) ? cnt : cnt + 8'd1;
  wire       sbe_hit = ev[0] && (cnt_inc >= thr);
  wire [2:0] set3    = {ev[2], ev[1], sbe_hit};
  wire       multi   = (|set3) && (|det[2:0]);
  wire [3:0] w1c     = wr_det ? (reg_wdata[3:0] & wmask[3:0]) : 4'b0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mask_hi <= '0; mask_lo <= '0; mask_chk <= '0; inj_en <= 1'b0; mirror <= 1'b0;
      cnt <= '0; thr <= '0; det <= '0; dis <= '0; ien <= '0;
    end else begin
      if (wr_mhi) mask_hi <= merge(mask_hi, reg_wdata, wmask);
      if (wr_mlo) mask_lo <= merge(mask_lo, reg_wdata, wmask);
      if (wr_ictl) begin
        if (reg_wstrb[0]) mask_chk <= reg_wdata[7:0];
        if (reg_wstrb[1]) begin
          mirror <= reg_wdata[8];
          inj_en <= reg_wdata[9];
        end
      end
      if (wr_sbe && reg_wstrb[0])  cnt <= reg_wdata[7:0];
      else if (ev[0])              cnt <= cnt_inc;
      if (wr_sbe && reg_wstrb[1])  thr <= reg_wdata[15:8];
      det <= (det & ~w1c) | {multi, set3};
      if (wr_dis && reg_wstrb[0]) dis <= reg_wdata[2:0];
      if (wr_ien && reg_wstrb[0]) ien <= reg_wdata[2:0];
    end
  end

  // First-error capture
  wire cap_take = (|ev) && !(cap_valid && !wr_cclr);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cap_addr <= '0; cap_data <= '0; cap_chk <= '0; cap_beat <= '0;
      cap_size <= '0; cap_src <= '0; cap_type <= '0; cap_valid <= 1'b0;
    end else if (cap_take) begin
      cap_addr <= rd_addr; cap_data <= rd_data; cap_chk <= rd_chk; cap_beat <= rd_beat;
      cap_size <= rd_size; cap_src <= rd_src; cap_type <= rd_type; cap_valid <= 1'b1;
    end else if (wr_cclr) begin
      cap_addr <= '0; cap_data <= '0; cap_chk <= '0; cap_beat <= '0;
      cap_size <= '0; cap_src <= '0; cap_type <= '0; cap_valid <= 1'b0;
    end
  end

  assign irq = |(det[2:0] & ien);

  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      A_MHI:  reg_rdata = 32'(mask_hi);
      A_MLO:  reg_rdata = 32'(mask_lo);
      A_ICTL: reg_rdata = {22'd0, inj_en, mirror, 8'(mask_chk)};
      A_SBE:  reg_rdata = {16'd0, thr, cnt};
      A_DET:  reg_rdata = {28'd0, det};
      A_DIS:  reg_rdata = {29'd0, dis};
      A_IEN:  reg_rdata = {29'd0, ien};
      A_CADR: reg_rdata = 32'(cap_addr);
      A_CHI:  reg_rdata = 32'(cap_data[DW-1:HW]);
      A_CLO:  reg_rdata = 32'(cap_data[HW-1:0]);
      A_CCHK: reg_rdata = 32'(cap_chk);
      A_CATR: reg_rdata = {cap_valid, 13'd0, cap_type, 3'd0, cap_src, 1'b0, cap_size, 1'b0, cap_beat};
      default: reg_rdata = '0;
    endcase
  end

  // Assertions
  p_inj_off_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !inj_en |-> (wr_data_out == wr_data_in && wr_chk_out == wr_chk_in));

  p_cnt_sat_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt == CNT_MAX && !(wr_sbe && reg_wstrb[0])) |=> cnt == CNT_MAX);

  p_det_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (det[1] && !(wr_det && reg_wstrb[0] && reg_wdata[1])) |=> det[1]);

  p_dis_mse_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid && dis[2] && !det[2]) |=> !det[2]);

  p_cap_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (cap_valid && !wr_cclr) |=> (cap_valid && $stable(cap_addr) && $stable(cap_data)));

  p_irq_src_r10: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (|det[2:0]));
endmodule

// File: tb/test_ecc_fault_ctl.sv
module test_ecc_fault_ctl;
  logic        clk = 0, rst_n = 0;
  logic        reg_we = 0;
  logic [3:0]  reg_addr = 0;
  logic [31:0] reg_wdata = 0;
  logic [3:0]  reg_wstrb = 0;
  logic [31:0] reg_rdata;
  logic [63:0] wr_data_in = 0, wr_data_out;
  logic [7:0]  wr_chk_in = 0, wr_chk_out;
  logic        rd_valid = 0, rd_sbe = 0, rd_mbe = 0, rd_mse = 0;
  logic [31:0] rd_addr = 0;
  logic [63:0] rd_data = 0;
  logic [7:0]  rd_chk = 0;
  logic [2:0]  rd_beat = 0, rd_size = 0;
  logic [4:0]  rd_src = 0;
  logic [1:0]  rd_type = 0;
  logic        irq;
  int checks = 0, errors = 0;

  always #4 clk = ~clk;

  ecc_fault_ctl i_ecc_fault_ctl (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_wstrb(reg_wstrb), .reg_rdata(reg_rdata), .wr_data_in(wr_data_in), .wr_chk_in(wr_chk_in),
    .wr_data_out(wr_data_out), .wr_chk_out(wr_chk_out), .rd_valid(rd_valid), .rd_sbe(rd_sbe),
    .rd_mbe(rd_mbe), .rd_mse(rd_mse), .rd_addr(rd_addr), .rd_data(rd_data), .rd_chk(rd_chk),
    .rd_beat(rd_beat), .rd_size(rd_size), .rd_src(rd_src), .rd_type(rd_type), .irq(irq));

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 0;
    @(negedge clk); @(negedge clk); rst_n = 1;
    @(negedge clk);
  endtask

  task automatic wreg(input logic [3:0] a, input logic [31:0] d, input logic [3:0] s);
    @(negedge clk);
    reg_we = 1; reg_addr = a; reg_wdata = d; reg_wstrb = s;
    @(negedge clk);
    reg_we = 0; reg_wstrb = 0;
  endtask

  task automatic rreg(input logic [3:0] a, output logic [31:0] d);
    reg_addr = a; #1; d = reg_rdata;
  endtask

  task automatic beat(input logic s, input logic m, input logic x, input logic [31:0] a,
                      input logic [63:0] d, input logic [7:0] c, input logic [2:0] b,
                      input logic [2:0] z, input logic [4:0] src, input logic [1:0] t);
    @(negedge clk);
    rd_valid = 1; rd_sbe = s; rd_mbe = m; rd_mse = x; rd_addr = a; rd_data = d;
    rd_chk = c; rd_beat = b; rd_size = z; rd_src = src; rd_type = t;
    @(negedge clk);
    rd_valid = 0; rd_sbe = 0; rd_mbe = 0; rd_mse = 0;
  endtask

  task automatic t_reset();
    logic [31:0] v;
    do_reset();
    for (int i = 0; i < 13; i++) begin
      rreg(4'(i), v);
      chk($sformatf("R11 reg %0d", i), v, 0);
    end
    chk("R11 irq", irq, 0);
  endtask

  task automatic t_inject();
    do_reset();
    wreg(0, 32'hF0F0_0001, 4'hF);
    wreg(1, 32'h8000_0100, 4'hF);
    wreg(2, 32'h0000_010F, 4'hF);
    wr_data_in = 64'h1234_5678_9ABC_DEA5; wr_chk_in = 8'h33; #1;
    chk("R1 data passthrough", wr_data_out, 64'h1234_5678_9ABC_DEA5);
    chk("R1 chk passthrough", wr_chk_out, 8'h33);
    wreg(2, 32'h0000_020F, 4'hF);
    wr_data_in = 64'h1234_5678_9ABC_DEA5; #1;
    chk("R2 data xor", wr_data_out, 64'h1234_5678_9ABC_DEA5 ^ 64'hF0F0_0001_8000_0100);
    chk("R2 chk xor", wr_chk_out, 8'h33 ^ 8'h0F);
    wreg(2, 32'h0000_030F, 4'hF);
    #1;
    chk("R3 mirror", wr_chk_out, 8'hA5 ^ 8'h0F);
  endtask

  task automatic t_counter();
    logic [31:0] v;
    do_reset();
    wreg(3, 32'h0000_2000, 4'h2);
    wreg(3, 32'h0000_00FD, 4'h1);
    rreg(3, v); chk("R4 count write keeps threshold", v, 32'h0000_20FD);
    wreg(3, 32'h0000_4011, 4'h2);
    rreg(3, v); chk("R4 threshold write keeps count", v, 32'h0000_40FD);
    for (int i = 0; i < 4; i++) beat(1, 0, 0, 32'h100, 0, 0, 0, 0, 0, 0);
    rreg(3, v); chk("R5 saturate at 255", v, 32'h0000_40FF);
    rreg(4, v); chk("R6 flag at threshold", v[0], 1);
  endtask

  task automatic t_threshold();
    logic [31:0] v;
    do_reset();
    wreg(6, 32'h1, 4'h1);
    wreg(3, 32'h0000_0300, 4'h2);
    beat(1, 0, 0, 32'h40, 0, 0, 0, 0, 0, 0);
    beat(1, 0, 0, 32'h48, 0, 0, 0, 0, 0, 0);
    rreg(4, v); chk("R6 below threshold", v, 0);
    chk("R10 irq below threshold", irq, 0);
    beat(1, 0, 0, 32'h50, 0, 0, 0, 0, 0, 0);
    rreg(4, v); chk("R6 at threshold", v, 1);
    chk("R10 irq at threshold", irq, 1);
    rreg(3, v); chk("R5 count three", v, 32'h0000_0303);
    rreg(7, v); chk("R9 first sbe captured", v, 32'h40);
  endtask

  task automatic t_detect();
    logic [31:0] v;
    do_reset();
    beat(1, 0, 0, 32'h8, 0, 0, 0, 0, 0, 0);
    rreg(4, v); chk("R6 zero threshold flags", v, 32'h1);
    wreg(4, 32'h1, 4'h1);
    beat(0, 1, 0, 32'h8, 0, 0, 0, 0, 0, 0);
    rreg(4, v); chk("R7 mbe flag", v, 32'h2);
    beat(0, 0, 1, 32'h8, 0, 0, 0, 0, 0, 0);
    rreg(4, v); chk("R7 multiple flag", v, 32'hE);
    wreg(4, 32'h8, 4'h1);
    rreg(4, v); chk("R7 w1c multiple only", v, 32'h6);
    wreg(4, 32'h6, 4'h1);
    rreg(4, v); chk("R7 w1c rest", v, 0);
  endtask

  task automatic t_disable();
    logic [31:0] v;
    do_reset();
    wreg(5, 32'h5, 4'h1);
    beat(0, 0, 1, 32'h20, 0, 0, 0, 0, 0, 0);
    beat(1, 0, 0, 32'h20, 0, 0, 0, 0, 0, 0);
    rreg(4, v); chk("R8 no flags", v, 0);
    rreg(3, v); chk("R8 no count", v, 0);
    rreg(11, v); chk("R8 no capture", v, 0);
    beat(0, 1, 0, 32'h24, 0, 0, 0, 0, 0, 0);
    rreg(4, v); chk("R8 mbe still detected", v, 32'h2);
  endtask

  task automatic t_capture();
    logic [31:0] v;
    do_reset();
    beat(0, 1, 0, 32'hDEAD_BEE0, 64'h0123_4567_89AB_CDEF, 8'h5A, 3'd5, 3'd3, 5'h11, 2'd2);
    beat(0, 0, 1, 32'h0000_1000, 64'h1, 8'h1, 3'd1, 3'd1, 5'h1, 2'd1);
    rreg(7, v);  chk("R9 addr", v, 32'hDEAD_BEE0);
    rreg(8, v);  chk("R9 data high", v, 32'h0123_4567);
    rreg(9, v);  chk("R9 data low", v, 32'h89AB_CDEF);
    rreg(10, v); chk("R9 check byte", v, 32'h5A);
    rreg(11, v); chk("R9 attributes", v, 32'h8002_1135);
    wreg(12, 0, 4'hF);
    rreg(11, v); chk("R9 clear attr", v, 0);
    rreg(7, v);  chk("R9 clear addr", v, 0);
    beat(0, 0, 1, 32'h0000_2000, 64'h2, 8'h2, 3'd2, 3'd2, 5'h2, 2'd3);
    rreg(7, v);  chk("R9 recapture addr", v, 32'h2000);
  endtask

  task automatic t_irq();
    do_reset();
    beat(0, 1, 0, 32'h0, 0, 0, 0, 0, 0, 0);
    chk("R10 irq masked", irq, 0);
    wreg(6, 32'h2, 4'h1);
    chk("R10 irq enabled", irq, 1);
    wreg(6, 32'h4, 4'h1);
    chk("R10 other enable", irq, 0);
    wreg(6, 32'h2, 4'h1);
    wreg(4, 32'h2, 4'h1);
    chk("R10 irq after clear", irq, 0);
  endtask

  initial begin
    #(8 * 200000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    t_reset();
    t_inject();
    t_counter();
    t_threshold();
    t_detect();
    t_disable();
    t_capture();
    t_irq();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule